// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Initialisation Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its cells refreshed. It owns the row and column strobes whenever it runs a refresh cycle. An access controller borrows the same strobes through a request and grant pair. After reset the block waits a programmable pause. It then runs a fixed number of back-to-back initialisation refresh cycles and only then raises `ready`. Host requests are refused until that point.

In normal operation an interval timer marks each moment a refresh falls due. A saturating counter of owed refreshes lets the access controller keep the strobes while refresh waits. When the counter fills, the grant is withdrawn and one refresh runs at once. When the host lets go, all owed refreshes run back to back. Two refresh styles are available, chosen per cycle by a mode input:
- **Column-strobe-first.** The device's own row counter is used, so no address is driven.
- **Row-strobe-only.** The block drives a row address from its own wrapping counter. This style has twice as many rows to cover, so it uses its own, shorter interval.

All timings are given in clock cycles as parameters.

Top module: `refresh_sched`

## Requirements
- R1: After reset `ras_n` and `cas_n` stay high and `ready` stays low for PAUSE_CYC clock edges. The first initialisation cycle drives a strobe low right after edge PAUSE_CYC+1 counted from reset release.
- R2: Exactly INIT_CYCLES refresh cycles run after the pause. Each is separated from the next by one idle cycle. `ready` rises right after edge PAUSE_CYC + INIT_CYCLES*(LEAD_CYC+RAS_LOW_CYC+PRE_CYC+1) and stays high until reset.
- R3: `host_gnt` is never high while `ready` is low.
- R4: In a column-strobe-first cycle (`mode_ras_only`=0 when the cycle starts):
  - `cas_n` is low for exactly LEAD_CYC cycles before `ras_n` falls.
  - `cas_n` stays low for the whole time `ras_n` is low, and rises together with `ras_n`.
  - `we_n` is high.
- R5: Every refresh cycle holds `ras_n` low for exactly RAS_LOW_CYC cycles. Two consecutive low pulses are separated by at least PRE_CYC+LEAD_CYC high cycles.
- R6: Once `ready` is high, `owed` rises by one every INTERVAL_CYC edges in column-strobe-first mode, the first time at edge ready+INTERVAL_CYC. In row-strobe-only mode the period is INTERVAL_RO_CYC.
- R7: `owed` never exceeds MAX_OWED. It drops by one on the edge that starts a refresh cycle, and changes by at most one per edge.
- R8: With `ready` high, the engine idle, `host_req` high and `owed` below MAX_OWED, `host_gnt` rises on the next edge and owed refreshes wait.
- R9: When `owed` reaches MAX_OWED while `host_gnt` is high, `host_gnt` falls on the next edge. The refresh cycle starts on the edge after that.
- R10: `ras_n` and `cas_n` are both high whenever `host_gnt` is high.
- R11: With `host_req` low, owed refreshes start one every LEAD_CYC+RAS_LOW_CYC+PRE_CYC+1 edges until `owed` is zero.
- R12: In a row-strobe-only cycle (`mode_ras_only`=1 when the cycle starts):
  - `cas_n` stays high.
  - `row_addr` shows the row while `ras_n` is low.
  - The row counter starts at zero after reset and advances by one, modulo 2^ROW_W, as `ras_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ras_only | input | 1 | 1 selects row-strobe-only refresh, 0 column-strobe-first |
| host_req | input | 1 | Access controller wants the strobes |
| host_gnt | output | 1 | Access controller owns the strobes |
| ready | output | 1 | Initialisation finished |
| ras_n | output | 1 | Row strobe from refresh, active low |
| cas_n | output | 1 | Column strobe from refresh, active low |
| we_n | output | 1 | Write enable from refresh, held high |
| row_addr | output | ROW_W | Row address for row-strobe-only refresh |
| owed | output | $clog2(MAX_OWED+1) | Number of refreshes owed |

## Verification
Counting edges from reset release:
- The first strobe activity is due after edge PAUSE_CYC+1.
- `ready` is due after edge PAUSE_CYC + INIT_CYCLES*(L+1), where L is the full cycle length.
- A grant follows a request or release by one edge. A forced release follows a full backlog by one edge, and the refresh starts one edge after that.
- `owed` steps exactly INTERVAL_CYC edges apart.

The bench keeps a running edge count and samples on the falling clock edge at exactly these computed edge numbers. A per-cycle monitor measures strobe pulse widths, the column lead and the row sequence at every row-strobe transition.

// File: rtl/rfs_pkg.sv
// Shared types for the refresh scheduler: strobe engine states and the
// start-up phases. No logic lives here.
package rfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_STROBE = 2'd2,
        ST_PRE    = 2'd3
    } rfs_state_e;

    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_INIT  = 2'd1,
        PH_RUN   = 2'd2
    } rfs_phase_e;

endpackage

// File: rtl/rfs_init_seq.sv
// Start-up sequencer. It counts the power-up pause, then asks for
// INIT_CYCLES refresh cycles and counts their completions, then holds
// ready high until reset.
// Assumes cyc_done pulses for one cycle at the end of each refresh cycle.
module rfs_init_seq
    import rfs_pkg::*;
#(
    parameter int PAUSE_CYC   = 50000,
    parameter int INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_done,
    output logic init_req,
    output logic ready
);

    localparam int PW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
    localparam int DW = $clog2(INIT_CYCLES + 1);

    rfs_phase_e      phase_q;
    logic [PW-1:0]   pause_cnt;
    logic [DW-1:0]   done_cnt;

    // Phase progression: pause, then init cycles, then run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_PAUSE;
            pause_cnt <= '0;
            done_cnt  <= '0;
        end else begin
            case (phase_q)
                PH_PAUSE: begin
                    if (pause_cnt == PW'(PAUSE_CYC - 1)) phase_q <= PH_INIT;
                    else                                pause_cnt <= pause_cnt + 1'b1;
                end
                PH_INIT: begin
                    if (cyc_done) begin
                        done_cnt <= done_cnt + 1'b1;
                        if (done_cnt == DW'(INIT_CYCLES - 1)) phase_q <= PH_RUN;
                    end
                end
                PH_RUN:  phase_q <= PH_RUN;
                default: phase_q <= PH_PAUSE;
            endcase
        end
    end

    assign init_req = (phase_q == PH_INIT);
    assign ready    = (phase_q == PH_RUN);

endmodule

// File: rtl/rfs_interval.sv
// Refresh interval timer. While enabled it emits a one-cycle tick every
// period. The period follows the current refresh style, since row-only
// refresh must cover more rows in the same retention time.
// Assumes both periods are at least 1.
module rfs_interval #(
    parameter int INTERVAL_CYC    = 3900,
    parameter int INTERVAL_RO_CYC = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sel_ro,
    output logic tick
);

    localparam int IMAX = (INTERVAL_CYC > INTERVAL_RO_CYC) ? INTERVAL_CYC : INTERVAL_RO_CYC;
    localparam int IW   = (IMAX > 1) ? $clog2(IMAX) : 1;

    logic [IW-1:0] cnt;
    logic [IW-1:0] limit;

    // Pick the terminal count for the current refresh style.
    always_comb limit = sel_ro ? IW'(INTERVAL_RO_CYC - 1) : IW'(INTERVAL_CYC - 1);

    assign tick = enable && (cnt >= limit);

    // Free-running period counter, held at zero until enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!enable) cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rfs_backlog.sv
// Saturating counter of owed refreshes. It increments on a due tick and
// decrements when a refresh starts; both in one cycle leave it unchanged.
// Assumes dec is only raised while the count is non-zero.
module rfs_backlog #(
    parameter int MAX_OWED = 8,
    localparam int OW      = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] count,
    output logic          full,
    output logic          any
);

    // Up/down count with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (count != OW'(MAX_OWED)) count <= count + 1'b1;
                2'b01:   if (count != '0)            count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full = (count == OW'(MAX_OWED));
    assign any  = (count != '0);

endmodule

// File: rtl/rfs_strobe_engine.sv
// Refresh cycle generator with a lead, strobe and precharge phase.
// - Column-first style: cas_n falls in the lead phase and stays low
//   through the strobe phase.
// - Row-only style: the lead phase is address setup with cas_n high.
// The row counter advances as each row-only strobe ends.
// Assumes start is only raised while idle, and each phase is at least
// one cycle long.
module rfs_strobe_engine
    import rfs_pkg::*;
#(
    parameter int LEAD_CYC    = 2,
    parameter int RAS_LOW_CYC = 13,
    parameter int PRE_CYC     = 8,
    parameter int ROW_W       = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ras_only,
    output logic             idle,
    output logic             cyc_done,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr
);

    localparam int M1 = (LEAD_CYC > RAS_LOW_CYC) ? LEAD_CYC : RAS_LOW_CYC;
    localparam int PM = (M1 > PRE_CYC) ? M1 : PRE_CYC;
    localparam int CW = (PM > 1) ? $clog2(PM) : 1;

    rfs_state_e       state_q;
    logic [CW-1:0]    cnt;
    logic             ro_q;
    logic [ROW_W-1:0] row_q;
    logic             lead_last, strobe_last, pre_last;

    assign lead_last   = (cnt == CW'(LEAD_CYC - 1));
    assign strobe_last = (cnt == CW'(RAS_LOW_CYC - 1));
    assign pre_last    = (cnt == CW'(PRE_CYC - 1));

    // Phase sequencing, style capture and row counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt     <= '0;
            ro_q    <= 1'b0;
            row_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_LEAD;
                        cnt     <= '0;
                        ro_q    <= ras_only;
                    end
                end
                ST_LEAD: begin
                    if (lead_last) begin
                        state_q <= ST_STROBE;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (strobe_last) begin
                        state_q <= ST_PRE;
                        cnt     <= '0;
                        if (ro_q) row_q <= row_q + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PRE: begin
                    if (pre_last) begin
                        state_q <= ST_IDLE;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle     = (state_q == ST_IDLE);
    assign cyc_done = (state_q == ST_PRE) && pre_last;
    assign ras_n    = (state_q != ST_STROBE);
    assign cas_n    = ro_q || !((state_q == ST_LEAD) || (state_q == ST_STROBE));
    assign we_n     = 1'b1;
    assign row_addr = row_q;

endmodule

// File: rtl/refresh_sched.sv
// Top of the refresh scheduler. It joins the start-up sequencer, interval
// timer, owed-refresh counter and strobe engine, and arbitrates the
// shared strobes against the access controller's request.
// Assumes the access controller drives the DRAM strobes only while
// host_gnt is high and gives them up the cycle host_gnt falls.
module refresh_sched #(
    parameter int PAUSE_CYC       = 50000,
    parameter int INIT_CYCLES     = 8,
    parameter int INTERVAL_CYC    = 3900,
    parameter int INTERVAL_RO_CYC = 1950,
    parameter int LEAD_CYC        = 2,
    parameter int RAS_LOW_CYC     = 13,
    parameter int PRE_CYC         = 8,
    parameter int MAX_OWED        = 8,
    parameter int ROW_W           = 13,
    localparam int OWED_W         = $clog2(MAX_OWED + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ras_only,
    input  logic              host_req,
    output logic              host_gnt,
    output logic              ready,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ROW_W-1:0]  row_addr,
    output logic [OWED_W-1:0] owed
);

    logic init_req, eng_idle, cyc_done, tick;
    logic owed_full, owed_any, start, gnt_q, gnt_d;

    rfs_init_seq #(
        .PAUSE_CYC   (PAUSE_CYC),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_done (cyc_done),
        .init_req (init_req),
        .ready    (ready)
    );

    rfs_interval #(
        .INTERVAL_CYC    (INTERVAL_CYC),
        .INTERVAL_RO_CYC (INTERVAL_RO_CYC)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ready),
        .sel_ro (mode_ras_only),
        .tick   (tick)
    );

    rfs_backlog #(
        .MAX_OWED (MAX_OWED)
    ) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (start && ready),
        .count (owed),
        .full  (owed_full),
        .any   (owed_any)
    );

    rfs_strobe_engine #(
        .LEAD_CYC    (LEAD_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .PRE_CYC     (PRE_CYC),
        .ROW_W       (ROW_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ras_only (mode_ras_only),
        .idle     (eng_idle),
        .cyc_done (cyc_done),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .row_addr (row_addr)
    );

    // Start a refresh when the strobes are free and one is due: always
    // during init, otherwise when the host is away or the backlog is full.
    always_comb begin
        start = eng_idle && !gnt_q &&
                (init_req || (ready && owed_any && (!host_req || owed_full)));
    end

    // Grant the host only after init, with the engine idle and room left.
    always_comb gnt_d = ready && host_req && eng_idle && !start && !owed_full;

    // Registered grant so ownership changes on clean clock boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= 1'b0;
        else        gnt_q <= gnt_d;
    end

    assign host_gnt = gnt_q;

endmodule

// File: rtl/refresh_sched_chk.sv
// Property checker for the refresh scheduler, attached by bind. It watches
// the top-level ports only.
module refresh_sched_chk #(
    parameter int MAX_OWED = 8,
    parameter int ROW_W    = 13,
    localparam int OW      = $clog2(MAX_OWED + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_gnt,
    input logic             ready,
    input logic             ras_n,
    input logic             cas_n,
    input logic [ROW_W-1:0] row_addr,
    input logic [OW-1:0]    owed
);

    p_gnt_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> ready);

    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_cas_leads_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    p_cas_falls_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ras_n);

    p_owed_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW'(MAX_OWED));

    p_owed_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owed == $past(owed)) || (owed == OW'($past(owed) + 1'b1)) ||
        (OW'(owed + 1'b1) == $past(owed)));

    p_full_revokes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && owed == OW'(MAX_OWED)) |=> !host_gnt);

    p_no_strobe_granted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> (ras_n && cas_n));

    p_row_advance_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && $past(cas_n)) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

endmodule

bind refresh_sched refresh_sched_chk #(
    .MAX_OWED (MAX_OWED),
    .ROW_W    (ROW_W)
) u_refresh_sched_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_gnt (host_gnt),
    .ready    (ready),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_addr (row_addr),
    .owed     (owed)
);

// File: tb/test_refresh_sched.sv
// Self-checking bench on a small configuration. Expected edge numbers are
// computed from the parameters; a monitor measures every strobe pulse.
module test_refresh_sched;

    localparam int P    = 20;
    localparam int N    = 4;
    localparam int ICBR = 40;
    localparam int IRO  = 20;
    localparam int LEAD = 2;
    localparam int RASL = 4;
    localparam int PRE  = 3;
    localparam int MAXO = 4;
    localparam int RW   = 3;
    localparam int L    = LEAD + RASL + PRE;
    localparam int RDY  = P + N * (L + 1);
    localparam int OWW  = $clog2(MAXO + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ras_only = 1'b0;
    logic host_req = 1'b1;
    logic host_gnt, ready, ras_n, cas_n, we_n;
    logic [RW-1:0]  row_addr;
    logic [OWW-1:0] owed;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    refresh_sched #(
        .PAUSE_CYC       (P),
        .INIT_CYCLES     (N),
        .INTERVAL_CYC    (ICBR),
        .INTERVAL_RO_CYC (IRO),
        .LEAD_CYC        (LEAD),
        .RAS_LOW_CYC     (RASL),
        .PRE_CYC         (PRE),
        .MAX_OWED        (MAXO),
        .ROW_W           (RW)
    ) i_refresh_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_ras_only (mode_ras_only),
        .host_req      (host_req),
        .host_gnt      (host_gnt),
        .ready         (ready),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .row_addr      (row_addr),
        .owed          (owed)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic at(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Strobe monitor state
    logic prev_ras = 1'b1;
    logic prev_cas = 1'b1;
    bit   ro_mode = 1'b0;
    int   cas_run = 0, ras_low_run = 0, ras_high_run = 0;
    int   ras_falls = 0, ro_falls = 0, exp_row = 0, max_owed = 0;

    // Measure every strobe transition and the grant exclusivity.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cas_n) cas_run++; else cas_run = 0;
            if (prev_ras && !ras_n) begin
                ras_falls++;
                chk("R5 precharge gap", (ras_high_run >= PRE + LEAD) ? 1 : 0, 1);
                if (ro_mode) begin
                    chk("R12 cas high in row-only", int'(cas_n), 1);
                    chk("R12 row address", int'(row_addr), exp_row);
                    exp_row = (exp_row + 1) % (1 << RW);
                    ro_falls++;
                end else begin
                    chk("R4 cas lead", cas_run, LEAD + 1);
                    chk("R4 we high", int'(we_n), 1);
                end
                ras_high_run = 0;
            end
            if (!prev_ras && ras_n) begin
                chk("R5 ras low width", ras_low_run, RASL);
                if (!ro_mode) begin
                    chk("R4 cas held through ras low", int'(prev_cas), 0);
                    chk("R4 cas released with ras", int'(cas_n), 1);
                end
                ras_low_run = 0;
            end
            if (ras_n) ras_high_run++; else ras_low_run++;
            if (host_gnt) begin
                chk("R10 strobes idle while granted", int'(ras_n && cas_n), 1);
                chk("R3 grant only when ready", int'(ready), 1);
            end
            if (int'(owed) > max_owed) max_owed = int'(owed);
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(4 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog expired at edge %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset ras_n", int'(ras_n), 1);
        chk("R1 reset cas_n", int'(cas_n), 1);
        chk("R1 reset ready", int'(ready), 0);
        chk("R7 reset owed", int'(owed), 0);
        chk("R12 reset row", int'(row_addr), 0);
        // R1 pause then first init cycle
        at(P);
        chk("R1 quiet during pause", ras_falls + cas_run, 0);
        chk("R1 cas_n high at pause end", int'(cas_n), 1);
        at(P + 1);
        chk("R1 first init cycle begins", int'(cas_n), 0);
        // R2 init cycle count and ready timing, R3 refusal
        at(RDY - 1);
        chk("R2 ready not yet", int'(ready), 0);
        chk("R3 host refused before ready", int'(host_gnt), 0);
        at(RDY);
        chk("R2 ready rises", int'(ready), 1);
        chk("R2 init cycle count", ras_falls, N);
        at(RDY + 1);
        chk("R8 grant one edge after ready", int'(host_gnt), 1);
        // R6 interval steps while host holds the strobes
        at(RDY + ICBR - 1);
        chk("R6 owed before first tick", int'(owed), 0);
        for (int k = 1; k <= MAXO; k++) begin
            at(RDY + k * ICBR);
            chk("R6 owed after tick", int'(owed), k);
        end
        chk("R8 refresh postponed under grant", ras_falls, N);
        chk("R9 grant still held at fill edge", int'(host_gnt), 1);
        at(RDY + MAXO * ICBR + 1);
        chk("R9 grant withdrawn when full", int'(host_gnt), 0);
        at(RDY + MAXO * ICBR + 2);
        chk("R9 forced refresh starts", int'(cas_n), 0);
        chk("R7 owed drops at start", int'(owed), MAXO - 1);
        at(RDY + MAXO * ICBR + 2 + LEAD);
        chk("R4 ras falls after lead", int'(ras_n), 0);
        at(RDY + MAXO * ICBR + 2 + L + 1);
        chk("R8 grant returns after refresh", int'(host_gnt), 1);
        // R11 drain with host gone
        at(240);
        host_req = 1'b0;
        at(241);
        chk("R11 grant released", int'(host_gnt), 0);
        chk("R11 owed before drain", int'(owed), 3);
        at(242);
        chk("R11 drain start 1", int'(owed), 2);
        at(244);
        chk("R11 ras low in drain", int'(ras_n), 0);
        at(252);
        chk("R11 drain start 2", int'(owed), 1);
        at(260);
        chk("R6 tick during drain", int'(owed), 2);
        at(262);
        chk("R11 drain start 3", int'(owed), 1);
        at(272);
        chk("R11 drained to zero", int'(owed), 0);
        at(300);
        chk("R6 next tick", int'(owed), 1);
        at(301);
        chk("R11 single refresh starts", int'(cas_n), 0);
        chk("R7 owed consumed", int'(owed), 0);
        // R12 row-only style with its shorter interval
        at(312);
        mode_ras_only = 1'b1;
        ro_mode = 1'b1;
        at(319);
        chk("R6 row-only interval not yet", int'(owed), 0);
        at(320);
        chk("R6 row-only interval tick", int'(owed), 1);
        at(560);
        chk("R12 row-only cycle count", ro_falls, 12);
        chk("R12 row counter wrapped", int'(row_addr), 12 % (1 << RW));
        chk("R7 owed never above cap", (max_owed <= MAXO) ? 1 : 0, 1);
        chk("R2 ready stays high", int'(ready), 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule